// File: doc/BRIEF.md
# Bus Access Debug Comparator Bank

This block holds three bus-access comparators, called A, B and C, and raises one match flag per comparator when a monitored bus access fits that comparator's programmed conditions. Each comparator stores a target address and a control byte. Comparator A also stores a data value. The monitored bus carries a valid strobe, an address, a data word, a direction (read or write) and a size (byte or word).

Software reaches all of the storage through one small register window. A two-bit window select chooses which comparator appears in the window, and a two-bit offset chooses the register inside it. While the debug logic is armed, every write through the window is dropped, so the programmed conditions cannot change under a running capture.

The comparators are deliberately unequal. Only A can invert its data test, and only B can demand one particular access size. A tag bit is stored in every comparator. When it is set, the size and data tests are removed, and the match depends on address and direction alone.

Top module: `dbg_cmp_bank`

## Requirements
- R1: Window select 0 shows comparator A, 1 shows B and 2 shows C. Inside the window, offset 0 is the control byte (zero-extended on read), offset 1 is the address register and offset 2 is the data register, which exists for A only. Offset 2 of B or C and offset 3 of any comparator read 0 and ignore writes.
- R2: With window select 3, reads return 0 and writes change nothing.
- R3: While `armed` is 1, a write through the window changes no register.
- R4: After reset, every control byte, address register and data register reads 0, and `matchOut` is 0.
- R5: Control byte bits are: bit0 enable, bit1 direction-check enable, bit2 direction value (1 = read), bit3 tag, bit4 size-check enable, bit5 size value (1 = byte, 0 = word), bit6 data inversion. Only the implemented bits are kept: A keeps mask 0x5F, B keeps mask 0x3F and C keeps mask 0x0F. Other bits read 0.
- R6: `matchOut[i]` is 1 in the cycle after a cycle in which `busValid` is 1, `busAddr` equals comparator i's address and every applicable qualifier passes. Otherwise it is 0.
- R7: A comparator whose enable bit is 0 never raises its match.
- R8: When direction-check enable is set, `busRead` must equal the direction value bit. When it is clear, direction is not tested.
- R9: When size-check enable is set and tag is clear, `busByte` must equal the size value. For A this value is always word (0), because A has no size value bit. When size-check enable is clear, size is not tested.
- R10: When tag is clear, A also requires that `busData` equals its data register (inversion bit 0) or differs from it (inversion bit 1). B and C do not test data.
- R11: When tag is set, the size check and the data check (including inversion) are skipped. The address and direction checks still apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| winSel | input | 2 | Comparator window select |
| regOfs | input | 2 | Register offset inside the window |
| regWrEn | input | 1 | Write strobe for the window |
| regWdata | input | W | Write data |
| regRdata | output | W | Read data of the selected register (combinational) |
| armed | input | 1 | Debug logic armed; blocks writes |
| busValid | input | 1 | Monitored access present this cycle |
| busAddr | input | W | Monitored address |
| busData | input | W | Monitored data |
| busRead | input | 1 | 1 = read access, 0 = write access |
| busByte | input | 1 | 1 = byte access, 0 = word access |
| matchOut | output | 3 | Registered match per comparator (bit0 = A) |

## Verification
A bus access driven in one cycle produces its match flag after exactly one register, so the bench drives each access on a falling edge and compares `matchOut` on the next falling edge, just before it drives the following access. A window write is taken at the rising edge inside its strobe cycle, so readbacks are made only after that strobe cycle has ended. Read data is combinational, so each read is sampled 1 ns after the select and offset are driven. The sweep covers every control pattern of every comparator against all 32 combinations of valid, address equality, data equality, direction and size, with the expected flag computed from the requirement text.

// File: rtl/dbg_cmp_pkg.sv
package dbg_cmp_pkg;
  localparam int CMP_N   = 3;
  localparam int CTL_W   = 8;
  localparam int B_EN    = 0;
  localparam int B_RWE   = 1;
  localparam int B_RW    = 2;
  localparam int B_TAG   = 3;
  localparam int B_SZE   = 4;
  localparam int B_SZ    = 5;
  localparam int B_INV   = 6;

  typedef struct packed {
    logic [CMP_N-1:0] ctlWr;
    logic [CMP_N-1:0] adrWr;
    logic             datWr;
  } dbg_strobe_t;

  // implemented control bits per comparator (0 = A, 1 = B, 2 = C)
  function automatic logic [CTL_W-1:0] ctlMask(input int idx);
    case (idx)
      0:       return 8'h5F;
      1:       return 8'h3F;
      default: return 8'h0F;
    endcase
  endfunction
endpackage

// File: rtl/dbg_cmp_ctrl.sv
module dbg_cmp_ctrl
  import dbg_cmp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  winSel,
  input  logic [1:0]  regOfs,
  input  logic        regWrEn,
  input  logic        armed,
  output dbg_strobe_t strobe
);
  logic winOk;
  assign winOk = regWrEn && !armed && (winSel != 2'b11);

  always_comb begin
    strobe = '0;
    if (winOk) begin
      case (regOfs)
        2'd0: strobe.ctlWr[winSel] = 1'b1;
        2'd1: strobe.adrWr[winSel] = 1'b1;
        2'd2: strobe.datWr = (winSel == 2'b00);
        default: ;
      endcase
    end
  end

  // R3: no strobe may leave while the debug logic is armed
  p_lock_armed_r3: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (strobe == '0));

  // R1: at most one register is addressed per write
  p_single_target_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.ctlWr, strobe.adrWr, strobe.datWr}));

  // R2: the unused window select produces no strobe
  p_sel3_inert_r2: assert property (@(posedge clk) disable iff (!rstN)
    (winSel == 2'b11) |-> (strobe == '0));
endmodule

// File: rtl/dbg_cmp_datapath.sv
module dbg_cmp_datapath
  import dbg_cmp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dbg_strobe_t      strobe,
  input  logic [1:0]       winSel,
  input  logic [1:0]       regOfs,
  input  logic [W-1:0]     regWdata,
  output logic [W-1:0]     regRdata,
  input  logic             busValid,
  input  logic [W-1:0]     busAddr,
  input  logic [W-1:0]     busData,
  input  logic             busRead,
  input  logic             busByte,
  output logic [CMP_N-1:0] matchOut
);
  logic [CTL_W-1:0] ctlQ [CMP_N];
  logic [W-1:0]     adrQ [CMP_N];
  logic [W-1:0]     datQ;
  logic [CMP_N-1:0] hitD;
  logic [CMP_N-1:0] matchQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             datQ <= '0;
    else if (strobe.datWr) datQ <= regWdata;
  end

  for (genvar g = 0; g < CMP_N; g++) begin : gCmp
    logic addrOk, rwOk, sizeOk, dataOk;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctlQ[g] <= '0;
        adrQ[g] <= '0;
      end else begin
        if (strobe.ctlWr[g]) ctlQ[g] <= regWdata[CTL_W-1:0] & ctlMask(g);
        if (strobe.adrWr[g]) adrQ[g] <= regWdata;
      end
    end

    assign addrOk = (busAddr == adrQ[g]);
    assign rwOk   = !ctlQ[g][B_RWE] || (busRead == ctlQ[g][B_RW]);
    assign sizeOk = ctlQ[g][B_TAG] || !ctlQ[g][B_SZE] || (busByte == ctlQ[g][B_SZ]);

    if (g == 0) begin : gData
      assign dataOk = ctlQ[g][B_TAG] || ((busData == datQ) ^ ctlQ[g][B_INV]);
    end else begin : gNoData
      assign dataOk = 1'b1;
    end

    assign hitD[g] = busValid && ctlQ[g][B_EN] && addrOk && rwOk && sizeOk && dataOk;

    // R7: a disabled comparator stays silent in the following cycle
    p_enable_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
      !ctlQ[g][B_EN] |=> !matchOut[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) matchQ <= '0;
    else       matchQ <= hitD;
  end
  assign matchOut = matchQ;

  always_comb begin
    regRdata = '0;
    if (winSel != 2'b11) begin
      case (regOfs)
        2'd0: regRdata = W'(ctlQ[winSel]);
        2'd1: regRdata = adrQ[winSel];
        2'd2: if (winSel == 2'b00) regRdata = datQ;
        default: ;
      endcase
    end
  end

  // R6: no access, no match one cycle later
  p_valid_needed_r6: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |=> (matchOut == '0));

  // R2: the unused window always reads zero
  p_sel3_reads_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (winSel == 2'b11) |-> (regRdata == '0));
endmodule

// File: rtl/dbg_cmp_bank.sv
module dbg_cmp_bank
  import dbg_cmp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       winSel,
  input  logic [1:0]       regOfs,
  input  logic             regWrEn,
  input  logic [W-1:0]     regWdata,
  output logic [W-1:0]     regRdata,
  input  logic             armed,
  input  logic             busValid,
  input  logic [W-1:0]     busAddr,
  input  logic [W-1:0]     busData,
  input  logic             busRead,
  input  logic             busByte,
  output logic [CMP_N-1:0] matchOut
);
  dbg_strobe_t strobe;

  dbg_cmp_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .winSel  (winSel),
    .regOfs  (regOfs),
    .regWrEn (regWrEn),
    .armed   (armed),
    .strobe  (strobe)
  );

  dbg_cmp_datapath #(.W(W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .winSel   (winSel),
    .regOfs   (regOfs),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .busValid (busValid),
    .busAddr  (busAddr),
    .busData  (busData),
    .busRead  (busRead),
    .busByte  (busByte),
    .matchOut (matchOut)
  );
endmodule

// File: tb/test_dbg_cmp_bank.sv
`timescale 1ns/1ps
module test_dbg_cmp_bank;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [1:0]   winSel = '0;
  logic [1:0]   regOfs = '0;
  logic         regWrEn = 1'b0;
  logic [W-1:0] regWdata = '0;
  logic [W-1:0] regRdata;
  logic         armed = 1'b0;
  logic         busValid = 1'b0;
  logic [W-1:0] busAddr = '0;
  logic [W-1:0] busData = '0;
  logic         busRead = 1'b0;
  logic         busByte = 1'b0;
  logic [2:0]   matchOut;

  int  nChk = 0;
  int  nBad = 0;
  bit  done = 1'b0;

  logic [W-1:0] tgtAdr [3] = '{16'h1200, 16'h3456, 16'h7A08};
  logic [W-1:0] tgtDat = 16'hA5C3;
  logic [7:0]   keepMask [3] = '{8'h5F, 8'h3F, 8'h0F};

  always #2 clk = ~clk;

  dbg_cmp_bank #(.W(W)) i_dbg_cmp_bank (
    .clk(clk), .rstN(rstN), .winSel(winSel), .regOfs(regOfs), .regWrEn(regWrEn),
    .regWdata(regWdata), .regRdata(regRdata), .armed(armed), .busValid(busValid),
    .busAddr(busAddr), .busData(busData), .busRead(busRead), .busByte(busByte),
    .matchOut(matchOut)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [1:0] o, input logic [W-1:0] v);
    @(negedge clk);
    winSel = s; regOfs = o; regWdata = v; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [1:0] s, input logic [1:0] o,
                       input logic [W-1:0] exp);
    @(negedge clk);
    winSel = s; regOfs = o;
    #1;
    check(req, regRdata, exp);
  endtask

  function automatic bit expHit(input int c, input logic [7:0] ctl, input bit aEq,
                                input bit dEq, input bit rd, input bit byt, input bit vld);
    logic [7:0] k;
    k = ctl & keepMask[c];
    return vld && k[0] && aEq && (!k[1] || (rd == k[2])) &&
           (k[3] || !k[4] || (byt == k[5])) &&
           ((c != 0) || k[3] || (dEq ^ k[6]));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++; nChk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R4: reset state
    check("R4 match", W'(matchOut), '0);
    for (int c = 0; c < 3; c++) begin
      rdChk("R4 ctl", 2'(c), 2'd0, '0);
      rdChk("R4 adr", 2'(c), 2'd1, '0);
    end
    rdChk("R4 dat", 2'd0, 2'd2, '0);

    // R1: program addresses and A's data, read them back
    for (int c = 0; c < 3; c++) wr(2'(c), 2'd1, tgtAdr[c]);
    wr(2'd0, 2'd2, tgtDat);
    for (int c = 0; c < 3; c++) rdChk("R1 adr", 2'(c), 2'd1, tgtAdr[c]);
    rdChk("R1 dat A", 2'd0, 2'd2, tgtDat);
    wr(2'd1, 2'd2, 16'hFFFF);
    rdChk("R1 dat B absent", 2'd1, 2'd2, '0);
    rdChk("R1 ofs3 A", 2'd0, 2'd3, '0);

    // R2: window 3 writes nothing, reads zero
    wr(2'd3, 2'd0, 16'h00FF);
    wr(2'd3, 2'd1, 16'hFFFF);
    for (int o = 0; o < 4; o++) rdChk("R2 sel3 read", 2'd3, 2'(o), '0);
    for (int c = 0; c < 3; c++) begin
      rdChk("R2 ctl untouched", 2'(c), 2'd0, '0);
      rdChk("R2 adr untouched", 2'(c), 2'd1, tgtAdr[c]);
    end

    // R3: writes blocked while armed
    armed = 1'b1;
    wr(2'd0, 2'd0, 16'h00FF);
    wr(2'd1, 2'd1, 16'h0BAD);
    wr(2'd0, 2'd2, 16'h0BAD);
    rdChk("R3 ctl locked", 2'd0, 2'd0, '0);
    rdChk("R3 adr locked", 2'd1, 2'd1, tgtAdr[1]);
    rdChk("R3 dat locked", 2'd0, 2'd2, tgtDat);
    armed = 1'b0;

    // R5..R11: sweep every control pattern of every comparator
    for (int c = 0; c < 3; c++) begin
      for (int p = 0; p < 128; p++) begin
        wr(2'(c), 2'd0, W'(p));
        rdChk("R5 kept bits", 2'(c), 2'd0, W'(8'(p) & keepMask[c]));
        for (int v = 0; v < 32; v++) begin
          bit vld, aEq, dEq, rd, byt;
          logic [2:0] exp;
          vld = v[0]; aEq = v[1]; dEq = v[2]; rd = v[3]; byt = v[4];
          @(negedge clk);
          busValid = vld;
          busAddr  = aEq ? tgtAdr[c] : (tgtAdr[c] ^ 16'h0001);
          busData  = dEq ? tgtDat : (tgtDat ^ 16'h0100);
          busRead  = rd;
          busByte  = byt;
          exp = '0;
          exp[c] = expHit(c, 8'(p), aEq, dEq, rd, byt, vld);
          @(negedge clk);
          busValid = 1'b0;
          check("R6 R7 R8 R9 R10 R11 match", W'(matchOut), W'(exp));
        end
      end
      wr(2'(c), 2'd0, '0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule